// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an operand-addressing request of a 16-bit processor into a 20-bit effective address. In that processor, every index register and the program counter carry a 4-bit extension field, and the extension field sits above the 16-bit register value. A request holds a mode code, an opcode operand word of up to 24 bits, an index select, a jump-class flag and a branch-taken flag. Each request is captured together with copies of IX, IY, IZ, their extensions, PC with its extension, the extension used by extended addressing, and accumulator E. On the cycle after capture, the block presents the address, a valid flag and an illegal-mode flag. In the post-modified index mode it also presents a write-back of the X register that the surrounding register file commits at the following clock edge.

The controller is a two-state machine. ST_IDLE is the resting state. A pulse on `start` takes the transition IDLE_TO_EVAL and captures the request. ST_EVAL is the single cycle in which outputs are driven. From ST_EVAL, a further `start` takes EVAL_TO_EVAL, so requests can run back to back. Without one, the machine takes EVAL_TO_IDLE. All additions wrap modulo 2^20, so carries and borrows pass from the 16-bit word into the extension field.

Top module: `eag_unit`

## Requirements
- R1: After reset, and in any cycle that does not follow a cycle with `start` high, `ea_valid`, `illegal` and `wb_en` are low and `ea` reads zero.
- R2: A request with `start` high at a rising edge produces its outputs during the following clock cycle only. The outputs use the register and operand values captured at that edge, and later changes to the inputs do not affect them.
- R3: Mode code 1 (extended) gives `ea` = {`ek`, `opnd[15:0]`}.
- R4: Mode code 2 (absolute 20-bit) with `jump_op` high gives `ea` = `opnd[19:0]`; `opnd[23:20]` is ignored.
- R5: Mode code 3 adds `opnd[7:0]`, treated as unsigned, to the selected index register and its extension. `idx_sel` 0, 1 and 2 select X, Y and Z.
- R6: Mode code 4 adds `opnd[15:0]`, sign-extended, to the selected index register and its extension, modulo 2^20.
- R7: Mode code 5 with `jump_op` high adds `opnd[19:0]` to the selected index register and its extension, modulo 2^20.
- R8: Mode code 6 adds `acc_e`, sign-extended to 20 bits, to the selected index register and its extension.
- R9: Mode codes 7 and 8 add the sign-extended `opnd[7:0]` (code 7) or `opnd[15:0]` (code 8) to {`pk`,`pc`} when `taken` is high. When `taken` is low, `ea_valid` stays low and `illegal` stays low.
- R10: Mode code 9 gives `ea` = {`xk`,`ix`} and raises `wb_en`. In the same cycle, {`wb_xk`,`wb_ix`} = {`xk`,`ix`} plus the sign-extended `opnd[7:0]`. `idx_sel` is ignored in this mode.
- R11: Mode code 0 (inherent) keeps `ea_valid`, `illegal` and `wb_en` low.
- R12: `illegal` is raised and `ea_valid` is kept low in three cases: mode code 2 or 5 with `jump_op` low, a mode code from 10 to 15, or `idx_sel` = 3 in mode code 3, 4, 5 or 6.
- R13: `ea` reads zero whenever `ea_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture a request at this edge |
| mode | input | 4 | Addressing mode code |
| idx_sel | input | 2 | Index register select (0 X, 1 Y, 2 Z) |
| jump_op | input | 1 | Instruction is a jump or jump-to-subroutine |
| taken | input | 1 | Branch condition satisfied |
| opnd | input | 24 | Operand word from the instruction |
| ek | input | 4 | Extension for extended mode |
| ix | input | 16 | Index register X |
| xk | input | 4 | Extension of X |
| iy | input | 16 | Index register Y |
| yk | input | 4 | Extension of Y |
| iz | input | 16 | Index register Z |
| zk | input | 4 | Extension of Z |
| pc | input | 16 | Program counter |
| pk | input | 4 | Extension of PC |
| acc_e | input | 16 | Accumulator E |
| ea | output | 20 | Effective address |
| ea_valid | output | 1 | Address present |
| illegal | output | 1 | Mode not allowed for this request |
| wb_en | output | 1 | Commit X write-back at next edge |
| wb_ix | output | 16 | New X value |
| wb_xk | output | 4 | New X extension |

## Verification
The bench targets the additions that cross the 16-bit boundary. An 8-bit unsigned offset of 0xFF must carry into the extension of X, and a design that sign-extends it would step backwards instead. Negative 16-bit, 20-bit and accumulator offsets must borrow out of the extension and wrap at 2^20, and a design that drops the sign or truncates to 16 bits leaves the extension wrong. The post-modified case checks that the address is the old X while the write-back holds X plus the offset; an early update would shift the address. The bench also covers branches not taken, 20-bit modes without a jump and an out-of-range index select, all of which must keep the valid flag low. It changes the inputs after capture, which exposes a design that reads them live instead of from the captured copies.

// File: rtl/eag_pkg.sv
`timescale 1ns/1ps
package eag_pkg;
    localparam int WORD_W = 16;
    localparam int EXT_W  = 4;
    localparam int ADDR_W = WORD_W + EXT_W;
    localparam int OPND_W = 24;
    localparam int NIDX   = 3;
    localparam int SEL_W  = 2;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MD_INH   = 4'd0,
        MD_EXT   = 4'd1,
        MD_EXT20 = 4'd2,
        MD_IDX8  = 4'd3,
        MD_IDX16 = 4'd4,
        MD_IDX20 = 4'd5,
        MD_ACCE  = 4'd6,
        MD_REL8  = 4'd7,
        MD_REL16 = 4'd8,
        MD_POSTX = 4'd9
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } state_e;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_ABS  = 3'd1,
        SRC_IDX  = 3'd2,
        SRC_PC   = 3'd3,
        SRC_XREG = 3'd4
    } src_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [SEL_W-1:0]  sel;
        logic              jump;
        logic              taken;
        logic [OPND_W-1:0] opnd;
        logic [EXT_W-1:0]  ek;
        logic [ADDR_W-1:0] xw;
        logic [ADDR_W-1:0] yw;
        logic [ADDR_W-1:0] zw;
        logic [ADDR_W-1:0] pcw;
        logic [WORD_W-1:0] acc_e;
    } req_t;
endpackage

// File: rtl/eag_base_sel.sv
`timescale 1ns/1ps
module eag_base_sel #(
    parameter int N     = 3,
    parameter int W     = 20,
    parameter int SEL_W = 2
) (
    input  logic [N-1:0][W-1:0] bases,
    input  logic [SEL_W-1:0]    sel,
    output logic [W-1:0]        base,
    output logic                sel_bad
);
    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_hit
        assign hit[g] = (int'(sel) == g);
    end

    always_comb begin
        base = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) base = base | bases[i];
        end
    end

    assign sel_bad = (hit == '0);

    always_comb begin
        assert ($onehot0(hit)) else $error("base select hit more than one register");
    end
endmodule

// File: rtl/eag_offset_gen.sv
`timescale 1ns/1ps
module eag_offset_gen
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [OPND_W-1:0] opnd,
    input  logic [EXT_W-1:0]  ek,
    input  logic [WORD_W-1:0] acc_e,
    output logic [ADDR_W-1:0] off,
    output src_e              src,
    output logic              need_jump,
    output logic              need_taken,
    output logic              idx_used,
    output logic              bad_mode
);
    localparam int B8_PAD  = ADDR_W - 8;
    localparam int W16_PAD = ADDR_W - WORD_W;

    logic [ADDR_W-1:0] zx8, sx8, sx16, sxe, abs20, ext_abs;

    assign zx8     = {{B8_PAD{1'b0}}, opnd[7:0]};
    assign sx8     = {{B8_PAD{opnd[7]}}, opnd[7:0]};
    assign sx16    = {{W16_PAD{opnd[WORD_W-1]}}, opnd[WORD_W-1:0]};
    assign sxe     = {{W16_PAD{acc_e[WORD_W-1]}}, acc_e};
    assign abs20   = opnd[ADDR_W-1:0];
    assign ext_abs = {ek, opnd[WORD_W-1:0]};

    always_comb begin
        off        = '0;
        src        = SRC_NONE;
        need_jump  = 1'b0;
        need_taken = 1'b0;
        idx_used   = 1'b0;
        bad_mode   = 1'b0;
        unique case (mode)
            MD_INH: ;
            MD_EXT: begin
                src = SRC_ABS;
                off = ext_abs;
            end
            MD_EXT20: begin
                src       = SRC_ABS;
                off       = abs20;
                need_jump = 1'b1;
            end
            MD_IDX8: begin
                src      = SRC_IDX;
                off      = zx8;
                idx_used = 1'b1;
            end
            MD_IDX16: begin
                src      = SRC_IDX;
                off      = sx16;
                idx_used = 1'b1;
            end
            MD_IDX20: begin
                src       = SRC_IDX;
                off       = abs20;
                idx_used  = 1'b1;
                need_jump = 1'b1;
            end
            MD_ACCE: begin
                src      = SRC_IDX;
                off      = sxe;
                idx_used = 1'b1;
            end
            MD_REL8: begin
                src        = SRC_PC;
                off        = sx8;
                need_taken = 1'b1;
            end
            MD_REL16: begin
                src        = SRC_PC;
                off        = sx16;
                need_taken = 1'b1;
            end
            MD_POSTX: begin
                src = SRC_XREG;
                off = '0;
            end
            default: bad_mode = 1'b1;
        endcase
    end
endmodule

// File: rtl/eag_adder.sv
`timescale 1ns/1ps
module eag_adder #(
    parameter int W = 20
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    logic [W:0] full;
    assign full = {1'b0, a} + {1'b0, b};
    assign sum  = full[W-1:0];
endmodule

// File: rtl/eag_unit.sv
`timescale 1ns/1ps
module eag_unit
    import eag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        mode,
    input  logic [1:0]        idx_sel,
    input  logic              jump_op,
    input  logic              taken,
    input  logic [23:0]       opnd,
    input  logic [3:0]        ek,
    input  logic [15:0]       ix,
    input  logic [3:0]        xk,
    input  logic [15:0]       iy,
    input  logic [3:0]        yk,
    input  logic [15:0]       iz,
    input  logic [3:0]        zk,
    input  logic [15:0]       pc,
    input  logic [3:0]        pk,
    input  logic [15:0]       acc_e,
    output logic [19:0]       ea,
    output logic              ea_valid,
    output logic              illegal,
    output logic              wb_en,
    output logic [15:0]       wb_ix,
    output logic [3:0]        wb_xk
);
    localparam int PM_PAD = ADDR_W - 8;

    state_e state_q, state_d;
    req_t   req_q;

    // state register and request capture
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EVAL;
            ST_EVAL: state_d = start ? ST_EVAL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                req_q.mode  <= mode;
                req_q.sel   <= idx_sel;
                req_q.jump  <= jump_op;
                req_q.taken <= taken;
                req_q.opnd  <= opnd;
                req_q.ek    <= ek;
                req_q.xw    <= {xk, ix};
                req_q.yw    <= {yk, iy};
                req_q.zw    <= {zk, iz};
                req_q.pcw   <= {pk, pc};
                req_q.acc_e <= acc_e;
            end
        end
    end

    // datapath
    logic [ADDR_W-1:0] off, base, lhs, sum, pm_off, pm_sum;
    src_e              src;
    logic              need_jump, need_taken, idx_used, bad_mode, sel_bad;

    eag_offset_gen u_off (
        .mode       (req_q.mode),
        .opnd       (req_q.opnd),
        .ek         (req_q.ek),
        .acc_e      (req_q.acc_e),
        .off        (off),
        .src        (src),
        .need_jump  (need_jump),
        .need_taken (need_taken),
        .idx_used   (idx_used),
        .bad_mode   (bad_mode)
    );

    eag_base_sel #(.N(NIDX), .W(ADDR_W), .SEL_W(SEL_W)) u_base (
        .bases   ({req_q.zw, req_q.yw, req_q.xw}),
        .sel     (req_q.sel),
        .base    (base),
        .sel_bad (sel_bad)
    );

    always_comb begin
        unique case (src)
            SRC_IDX:  lhs = base;
            SRC_PC:   lhs = req_q.pcw;
            SRC_XREG: lhs = req_q.xw;
            default:  lhs = '0;
        endcase
    end

    eag_adder #(.W(ADDR_W)) u_ea_add (
        .a   (lhs),
        .b   (off),
        .sum (sum)
    );

    assign pm_off = {{PM_PAD{req_q.opnd[7]}}, req_q.opnd[7:0]};

    eag_adder #(.W(ADDR_W)) u_pm_add (
        .a   (req_q.xw),
        .b   (pm_off),
        .sum (pm_sum)
    );

    // output process
    logic in_eval, fault, produce;
    always_comb begin
        in_eval  = (state_q == ST_EVAL);
        fault    = bad_mode | (need_jump & ~req_q.jump) | (idx_used & sel_bad);
        produce  = (src != SRC_NONE) && (!need_taken || req_q.taken);
        illegal  = in_eval & fault;
        ea_valid = in_eval & ~fault & produce;
        ea       = ea_valid ? sum : '0;
        wb_en    = in_eval & (src == SRC_XREG);
        wb_ix    = wb_en ? pm_sum[WORD_W-1:0] : '0;
        wb_xk    = wb_en ? pm_sum[ADDR_W-1:WORD_W] : '0;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!ea_valid && !illegal && !wb_en));
    // R2
    start_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == ST_EVAL));
    // R2
    drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !ea_valid);
    // R9
    not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_eval && need_taken && !req_q.taken) |-> !ea_valid);
    // R10
    postmod_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (ea_valid && ea == req_q.xw));
    // R11
    inherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_eval && req_q.mode == MD_INH) |-> (!ea_valid && !illegal));
    // R12
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!ea_valid && !wb_en));
    // R13
    zero_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ea_valid |-> (ea == '0));
endmodule

// File: tb/sim_eag_unit.sv
`timescale 1ns/1ps
module sim_eag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  idx_sel = '0;
    logic        jump_op = 1'b0, taken = 1'b0;
    logic [23:0] opnd = '0;
    logic [3:0]  ek = 4'hA, xk = 4'h2, yk = 4'h5, zk = 4'h0, pk = 4'h1;
    logic [15:0] ix = 16'hFFF0, iy = 16'h1234, iz = 16'h0010, pc = 16'h0004;
    logic [15:0] acc_e = 16'h8000;
    logic [19:0] ea;
    logic        ea_valid, illegal, wb_en;
    logic [15:0] wb_ix;
    logic [3:0]  wb_xk;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    eag_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .idx_sel(idx_sel),
        .jump_op(jump_op), .taken(taken), .opnd(opnd), .ek(ek),
        .ix(ix), .xk(xk), .iy(iy), .yk(yk), .iz(iz), .zk(zk),
        .pc(pc), .pk(pk), .acc_e(acc_e),
        .ea(ea), .ea_valid(ea_valid), .illegal(illegal),
        .wb_en(wb_en), .wb_ix(wb_ix), .wb_xk(wb_xk)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive a request and move to the output cycle
    task automatic issue(input logic [3:0] m, input logic [1:0] s, input logic j,
                         input logic t, input logic [23:0] op);
        @(negedge clk);
        mode = m; idx_sel = s; jump_op = j; taken = t; opnd = op; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_ea(input string req, input logic [19:0] exp);
        chk({req, " valid"}, {31'd0, ea_valid}, 32'd1);
        chk({req, " ea"}, {12'd0, ea}, {12'd0, exp});
        chk({req, " illegal"}, {31'd0, illegal}, 32'd0);
    endtask

    task automatic expect_none(input string req, input logic ill);
        chk({req, " valid"}, {31'd0, ea_valid}, 32'd0);
        chk({req, " ea"}, {12'd0, ea}, 32'd0);
        chk({req, " illegal"}, {31'd0, illegal}, {31'd0, ill});
        chk({req, " wb_en"}, {31'd0, wb_en}, 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        expect_none("R1 reset", 1'b0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        mode = 4'd1; opnd = 24'h00BEEF; start = 1'b1;
        @(negedge clk);
        start = 1'b0; ek = 4'h3; opnd = 24'h001111;
        expect_ea("R2 captured values", 20'hABEEF);
        @(negedge clk);
        expect_none("R2 drop after one cycle", 1'b0);
        ek = 4'hA;
    endtask

    task automatic t_extended;
        issue(4'd1, 2'd0, 1'b0, 1'b0, 24'h00BEEF);
        expect_ea("R3 extended", 20'hABEEF);
        issue(4'd2, 2'd0, 1'b1, 1'b0, 24'hF54321);
        expect_ea("R4 absolute20", 20'h54321);
    endtask

    task automatic t_indexed;
        issue(4'd3, 2'd0, 1'b0, 1'b0, 24'h0000FF);
        expect_ea("R5 idx8 X carry", 20'h300EF);
        issue(4'd3, 2'd1, 1'b0, 1'b0, 24'h000080);
        expect_ea("R5 idx8 Y", 20'h512B4);
        issue(4'd3, 2'd2, 1'b0, 1'b0, 24'h000001);
        expect_ea("R5 idx8 Z", 20'h00011);
        issue(4'd4, 2'd2, 1'b0, 1'b0, 24'h00FFE0);
        expect_ea("R6 idx16 negative wrap", 20'hFFFF0);
        issue(4'd4, 2'd1, 1'b0, 1'b0, 24'h007000);
        expect_ea("R6 idx16 positive", 20'h58234);
        issue(4'd5, 2'd1, 1'b1, 1'b0, 24'h0FFFFF);
        expect_ea("R7 idx20 minus one", 20'h51233);
    endtask

    task automatic t_acc;
        issue(4'd6, 2'd0, 1'b0, 1'b0, 24'h0);
        expect_ea("R8 acc negative", 20'h27FF0);
        acc_e = 16'h0100;
        issue(4'd6, 2'd2, 1'b0, 1'b0, 24'h0);
        expect_ea("R8 acc positive", 20'h00110);
        acc_e = 16'h8000;
    endtask

    task automatic t_relative;
        issue(4'd7, 2'd0, 1'b0, 1'b1, 24'h0000F0);
        expect_ea("R9 rel8 taken", 20'h0FFF4);
        issue(4'd7, 2'd0, 1'b0, 1'b0, 24'h0000F0);
        expect_none("R9 rel8 not taken", 1'b0);
        issue(4'd8, 2'd0, 1'b0, 1'b1, 24'h008000);
        expect_ea("R9 rel16 taken", 20'h08004);
    endtask

    task automatic t_postmod;
        issue(4'd9, 2'd1, 1'b0, 1'b0, 24'h000020);
        expect_ea("R10 postmod ea", 20'h2FFF0);
        chk("R10 wb_en", {31'd0, wb_en}, 32'd1);
        chk("R10 wb value", {12'd0, wb_xk, wb_ix}, 32'h30010);
        issue(4'd9, 2'd0, 1'b0, 1'b0, 24'h0000F0);
        chk("R10 wb negative", {12'd0, wb_xk, wb_ix}, 32'h2FFE0);
        @(negedge clk);
        chk("R10 wb_en one cycle", {31'd0, wb_en}, 32'd0);
    endtask

    task automatic t_inherent;
        issue(4'd0, 2'd0, 1'b1, 1'b1, 24'h123456);
        expect_none("R11 inherent", 1'b0);
    endtask

    task automatic t_illegal;
        issue(4'd2, 2'd0, 1'b0, 1'b0, 24'h054321);
        expect_none("R12 abs20 no jump", 1'b1);
        issue(4'd5, 2'd0, 1'b0, 1'b0, 24'h000010);
        expect_none("R12 idx20 no jump", 1'b1);
        issue(4'd12, 2'd0, 1'b1, 1'b1, 24'h000010);
        expect_none("R12 undefined mode", 1'b1);
        issue(4'd3, 2'd3, 1'b0, 1'b0, 24'h000010);
        expect_none("R12 bad index select", 1'b1);
        issue(4'd7, 2'd3, 1'b0, 1'b0, 24'h000010);
        expect_none("R13 zero ea when invalid", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_extended();
        t_indexed();
        t_acc();
        t_relative();
        t_postmod();
        t_inherent();
        t_illegal();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule